// File: doc/BRIEF.md
# Half-Bridge Gate Driver Control Logic

This block sits between a multiphase buck controller and the gate drivers of one synchronous power stage. It receives a three-level PWM request that an external window comparator has already decoded, plus an active-low enable, an active-low skip request and a supply-good flag from an external undervoltage comparator that supplies its own hysteresis. From these it produces registered enables for the high-side and low-side switches.

The block guarantees break-before-make switching through a dead-time counter. It applies a minimum on-time to the high-side switch. A mid-level PWM input turns both switches off only after it has persisted for a hold-off window. When the stage is enabled, the block fires a fixed-width low-side pulse that recharges the bootstrap capacitor.

Conflicting requests are resolved by a fixed priority, highest first: lockout, disable, pre-charge, tri-state shutdown, skip suppression, then normal PWM. Every input passes through a two-flop synchroniser before it is used.

Top module: `hb_gate_ctrl`

## Requirements
- R1: While rst_ni is low both gate outputs are 0. The synchronisers reset to a state that reads as disabled, skip inactive, supply not good and PWM low, so both gates stay off after reset until enable and supply-good are seen high.
- R2: gate_hi_o and gate_lo_o are never 1 together. Either output rises only after both outputs have been 0 for at least DEAD_CYC consecutive cycles.
- R3: PWM encoding is 2'b00 low, 2'b01 high, 2'b10 mid, and 2'b11 is also treated as mid. High turns the low side off and then the high side on; low does the reverse. When no dead-time or on-time wait applies, the gate change appears on the third rising clock edge after the input change.
- R4: Once gate_hi_o rises, it stays high for at least MIN_ON_CYC cycles against PWM low or skip requests. Lockout, disable and tri-state shutdown may cut it short.
- R5: A mid PWM level lasting HOLD_CYC consecutive synchronised cycles turns both gates off. A shorter mid excursion leaves the gates as the last high/low level set them. Leaving mid resumes normal control at once.
- R6: While dis_ni is low both gates are off, even during a high-side minimum on-time.
- R7: A low-to-high transition of dis_ni drives gate_lo_o high for exactly PRE_CYC cycles, after which normal PWM control resumes.
- R8: While skip_ni is low gate_lo_o is held off (except during the pre-charge pulse); the high side still follows PWM.
- R9: While supply_ok_i is low both gates are off at highest priority. Its return to high does not start a pre-charge pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_lvl_i | input | 2 | Decoded PWM level: 00 low, 01 high, 1x mid |
| dis_ni | input | 1 | Driver enable, low shuts the stage down |
| skip_ni | input | 1 | Low-side suppression request, active low |
| supply_ok_i | input | 1 | Supply above lockout threshold |
| gate_hi_o | output | 1 | High-side switch enable |
| gate_lo_o | output | 1 | Low-side switch enable |

## Verification
Several rules are checked on every cycle: the two gates never overlap, the dead time before any rise, gates off one cycle after a synchronised disable or lockout, low side off under skip, shutdown after an expired tri-state window, and the high-side minimum pulse when no override is present. The bench scenarios cover what a cycle-local property cannot show. These are the exact pre-charge width, the end-to-end latency from pin to gate, and holding the previous state through a short mid excursion. They also show that returning from lockout produces no pre-charge pulse and that the 2'b11 code behaves as mid.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    PWM_LO   = 2'b00,
    PWM_HI   = 2'b01,
    PWM_MID  = 2'b10,
    PWM_MIDX = 2'b11
  } pwm_lvl_e;

  typedef enum logic [1:0] {
    REQ_OFF = 2'b00,
    REQ_HI  = 2'b01,
    REQ_LO  = 2'b10
  } req_kind_e;

  typedef struct packed {
    req_kind_e kind;
    logic      force_off;  // bypass high-side minimum on-time
  } gate_req_t;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff <= {2{RST_VAL[b]}};
      else         ff <= {ff[0], d_i[b]};
    end
    assign q_o[b] = ff[1];
  end
endmodule

// File: rtl/hb_mode_arb.sv
module hb_mode_arb
  import hb_pkg::*;
#(
  parameter int HOLD_CYC = 8,
  parameter int PRE_CYC  = 12
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pwm_lvl_e  pwm_s_i,
  input  logic      dis_s_i,
  input  logic      skip_s_i,
  input  logic      ok_s_i,
  output gate_req_t req_o,
  output logic      pre_act_o,
  output logic      tri_hit_o
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int PW = $clog2(PRE_CYC + 1);
  localparam logic [HW-1:0] HOLD_V = HW'(HOLD_CYC);
  localparam logic [PW-1:0] PRE_V  = PW'(PRE_CYC);

  logic [HW-1:0] mid_cnt;
  logic [PW-1:0] pre_cnt;
  logic          dis_q;
  logic          last_hi;
  logic          is_mid, dis_rise, eff_hi;

  assign is_mid    = pwm_s_i[1];
  assign dis_rise  = dis_s_i & ~dis_q;
  assign pre_act_o = dis_rise | (pre_cnt != '0);
  assign tri_hit_o = is_mid & (mid_cnt == HOLD_V);
  // short mid excursions keep the last two-level decision
  assign eff_hi    = is_mid ? last_hi : pwm_s_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mid_cnt <= '0;
      pre_cnt <= '0;
      dis_q   <= 1'b0;
      last_hi <= 1'b0;
    end else begin
      dis_q <= dis_s_i;
      if (!is_mid) begin
        mid_cnt <= '0;
        last_hi <= pwm_s_i[0];
      end else if (mid_cnt != HOLD_V) begin
        mid_cnt <= mid_cnt + 1'b1;
      end
      if (!ok_s_i || !dis_s_i)  pre_cnt <= '0;
      else if (dis_rise)        pre_cnt <= PRE_V - 1'b1;
      else if (pre_cnt != '0)   pre_cnt <= pre_cnt - 1'b1;
    end
  end

  always_comb begin
    req_o = '{kind: REQ_OFF, force_off: 1'b1};
    if (!ok_s_i || !dis_s_i) begin
      req_o = '{kind: REQ_OFF, force_off: 1'b1};
    end else if (pre_act_o) begin
      req_o = '{kind: REQ_LO, force_off: 1'b1};
    end else if (tri_hit_o) begin
      req_o = '{kind: REQ_OFF, force_off: 1'b1};
    end else if (eff_hi) begin
      req_o = '{kind: REQ_HI, force_off: 1'b0};
    end else if (!skip_s_i) begin
      req_o = '{kind: REQ_OFF, force_off: 1'b0};
    end else begin
      req_o = '{kind: REQ_LO, force_off: 1'b0};
    end
  end
endmodule

// File: rtl/hb_gate_stage.sv
module hb_gate_stage
  import hb_pkg::*;
#(
  parameter int DEAD_CYC   = 2,
  parameter int MIN_ON_CYC = 6
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  gate_req_t req_i,
  output logic      gate_hi_o,
  output logic      gate_lo_o
);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam int MW = $clog2(MIN_ON_CYC + 1);
  localparam logic [DW-1:0] DEAD_V = DW'(DEAD_CYC);
  localparam logic [MW-1:0] MIN_V  = MW'(MIN_ON_CYC);

  logic          hi_q, lo_q, hi_d, lo_d;
  logic [DW-1:0] idle_cnt;
  logic [MW-1:0] hi_cnt;
  logic          idle_ok, hold_hi;

  assign idle_ok = (idle_cnt >= DEAD_V);
  assign hold_hi = hi_q & (hi_cnt < MIN_V - 1'b1) & ~req_i.force_off;

  always_comb begin
    hi_d = 1'b0;
    lo_d = 1'b0;
    unique case (req_i.kind)
      REQ_HI: hi_d = hi_q | (~lo_q & idle_ok);
      REQ_LO: begin
        if (hold_hi) hi_d = 1'b1;
        else         lo_d = lo_q | (~hi_q & idle_ok);
      end
      default: hi_d = hold_hi;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q     <= 1'b0;
      lo_q     <= 1'b0;
      idle_cnt <= '0;
      hi_cnt   <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
      if (hi_q || lo_q)  idle_cnt <= '0;
      else if (!idle_ok) idle_cnt <= idle_cnt + 1'b1;
      if (!hi_q)                hi_cnt <= '0;
      else if (hi_cnt != MIN_V) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  assign gate_hi_o = hi_q;
  assign gate_lo_o = lo_q;
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_pkg::*;
#(
  parameter int DEAD_CYC   = 2,
  parameter int MIN_ON_CYC = 6,
  parameter int HOLD_CYC   = 8,
  parameter int PRE_CYC    = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] pwm_lvl_i,
  input  logic       dis_ni,
  input  logic       skip_ni,
  input  logic       supply_ok_i,
  output logic       gate_hi_o,
  output logic       gate_lo_o
);
  localparam int SW = 5;
  // reset reads as: pwm low, disabled, skip inactive, supply not good
  localparam logic [SW-1:0] SYNC_RST = 5'b00_0_1_0;

  logic [SW-1:0] sync_q;
  pwm_lvl_e      pwm_s;
  logic          dis_s, skip_s, ok_s;
  logic          pre_act, tri_hit;
  gate_req_t     req;

  hb_sync #(.W(SW), .RST_VAL(SYNC_RST)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pwm_lvl_i, dis_ni, skip_ni, supply_ok_i}),
    .q_o   (sync_q)
  );

  assign pwm_s  = pwm_lvl_e'(sync_q[4:3]);
  assign dis_s  = sync_q[2];
  assign skip_s = sync_q[1];
  assign ok_s   = sync_q[0];

  hb_mode_arb #(.HOLD_CYC(HOLD_CYC), .PRE_CYC(PRE_CYC)) i_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwm_s_i  (pwm_s),
    .dis_s_i  (dis_s),
    .skip_s_i (skip_s),
    .ok_s_i   (ok_s),
    .req_o    (req),
    .pre_act_o(pre_act),
    .tri_hit_o(tri_hit)
  );

  hb_gate_stage #(.DEAD_CYC(DEAD_CYC), .MIN_ON_CYC(MIN_ON_CYC)) i_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req),
    .gate_hi_o(gate_hi_o),
    .gate_lo_o(gate_lo_o)
  );
endmodule

// File: rtl/hb_gate_ctrl_chk.sv
module hb_gate_ctrl_chk #(
  parameter int DEAD_CYC   = 2,
  parameter int MIN_ON_CYC = 6
) (
  input logic clk_i,
  input logic rst_ni,
  input logic gate_hi_o,
  input logic gate_lo_o,
  input logic dis_s,
  input logic ok_s,
  input logic skip_s,
  input logic pre_act,
  input logic tri_hit
);
  localparam int CW = $clog2(DEAD_CYC + MIN_ON_CYC + 2) + 1;

  logic [CW-1:0] low_run, hi_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run <= '0;
      hi_run  <= '0;
    end else begin
      if (gate_hi_o || gate_lo_o) low_run <= '0;
      else if (low_run != '1)     low_run <= low_run + 1'b1;
      if (!gate_hi_o)             hi_run  <= '0;
      else if (hi_run != '1)      hi_run  <= hi_run + 1'b1;
    end
  end

  // R2
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_hi_o && gate_lo_o));

  // R2
  dead_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_hi_o) |-> int'(low_run) >= DEAD_CYC);

  // R2
  dead_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_lo_o) |-> int'(low_run) >= DEAD_CYC);

  // R6
  disable_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dis_s |=> (!gate_hi_o && !gate_lo_o));

  // R9
  lockout_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ok_s |=> (!gate_hi_o && !gate_lo_o));

  // R8
  skip_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!skip_s && !pre_act) |=> !gate_lo_o);

  // R5
  tri_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tri_hit && !pre_act) |=> (!gate_hi_o && !gate_lo_o));

  // R4
  min_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(gate_hi_o) && $past(ok_s && dis_s && !tri_hit)) |-> int'(hi_run) >= MIN_ON_CYC);
endmodule

bind hb_gate_ctrl hb_gate_ctrl_chk #(
  .DEAD_CYC  (DEAD_CYC),
  .MIN_ON_CYC(MIN_ON_CYC)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .gate_hi_o(gate_hi_o),
  .gate_lo_o(gate_lo_o),
  .dis_s    (dis_s),
  .ok_s     (ok_s),
  .skip_s   (skip_s),
  .pre_act  (pre_act),
  .tri_hit  (tri_hit)
);

// File: tb/test_hb_gate_ctrl.sv
`timescale 1ns/1ps
module test_hb_gate_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic [1:0] pwm;
  logic       dis_n, skip_n, ok;
  logic       g_hi, g_lo;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  int base;

  typedef struct {
    int    at;
    bit    hi;
    bit    lo;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hb_gate_ctrl i_hb_gate_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .pwm_lvl_i  (pwm),
    .dis_ni     (dis_n),
    .skip_ni    (skip_n),
    .supply_ok_i(ok),
    .gate_hi_o  (g_hi),
    .gate_lo_o  (g_lo)
  );

  function automatic void compare(bit eh, bit el, string tag);
    n_cmp++;
    if (g_hi !== eh || g_lo !== el) begin
      n_bad++;
      $display("FAIL %s @cyc %0d: hi/lo=%b%b expected %b%b", tag, cyc, g_hi, g_lo, eh, el);
    end
  endfunction

  task automatic push(int at, bit h, bit l, string tag);
    exp_t e;
    e.at = at; e.hi = h; e.lo = l; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic go(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expectations as their cycle arrives
  always @(negedge clk) begin : mon
    exp_t it;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      it = sb.pop_front();
      compare(it.hi, it.lo, it.tag);
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, actual running expected done");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; pwm = 2'b00; dis_n = 1'b0; skip_n = 1'b1; ok = 1'b0;
    go(3);
    compare(0, 0, "R1 in reset");
    rst_ni = 1'b1;
    go(4);
    compare(0, 0, "R1 after reset");
    ok = 1'b1;
    go(6);
    compare(0, 0, "R6 disabled with supply good");

    // pre-charge then dead time into high side
    pwm = 2'b01;
    go(5);
    base = cyc; dis_n = 1'b1;
    push(base + 2,  0, 0, "R7 before pulse");
    push(base + 3,  0, 1, "R7 pulse start");
    push(base + 14, 0, 1, "R7 pulse last");
    push(base + 15, 0, 0, "R7 pulse end");
    push(base + 17, 0, 0, "R2 dead gap");
    push(base + 18, 1, 0, "R3 high after pre-charge");
    go(22);

    // high to low
    base = cyc; pwm = 2'b00;
    push(base + 2, 1, 0, "R3 latency hold");
    push(base + 3, 0, 0, "R3 high off");
    push(base + 5, 0, 0, "R2 dead gap");
    push(base + 6, 0, 1, "R3 low on");
    go(10);

    // short high pulse stretched to minimum on-time
    base = cyc; pwm = 2'b01;
    push(base + 3, 0, 0, "R3 low off");
    push(base + 5, 0, 0, "R2 dead gap");
    push(base + 6, 1, 0, "R3 high on");
    go(4);
    pwm = 2'b00;
    push(base + 11, 1, 0, "R4 min on held");
    push(base + 12, 0, 0, "R4 min on end");
    push(base + 14, 0, 0, "R2 dead gap");
    push(base + 15, 0, 1, "R3 low after min on");
    go(16);

    // skip mode
    base = cyc; skip_n = 1'b0;
    push(base + 2, 0, 1, "R8 before skip");
    push(base + 3, 0, 0, "R8 low side dropped");
    go(6);
    base = cyc; pwm = 2'b01;
    push(base + 3, 1, 0, "R3 third-edge latency");
    go(10);
    base = cyc; pwm = 2'b00;
    push(base + 3, 0, 0, "R8 high off, low held off");
    push(base + 8, 0, 0, "R8 low still off");
    go(10);
    base = cyc; skip_n = 1'b1;
    push(base + 2, 0, 0, "R8 skip release latency");
    push(base + 3, 0, 1, "R8 low resumes");
    go(6);

    // short mid excursion (HOLD-1 cycles)
    base = cyc; pwm = 2'b10;
    push(base + 5,  0, 1, "R5 short mid holds");
    push(base + 9,  0, 1, "R5 short mid holds");
    push(base + 12, 0, 1, "R5 after short mid");
    go(7);
    pwm = 2'b00;
    go(10);

    // long mid using code 2'b11
    base = cyc; pwm = 2'b11;
    push(base + 10, 0, 1, "R5 hold-off not expired");
    push(base + 11, 0, 0, "R5 tri-state off");
    push(base + 20, 0, 0, "R5 tri-state stays off");
    go(25);
    base = cyc; pwm = 2'b00;
    push(base + 2, 0, 0, "R5 leave mid latency");
    push(base + 3, 0, 1, "R5 resume low");
    go(6);

    // disable cuts high side during min on-time
    base = cyc; pwm = 2'b01;
    go(5);
    dis_n = 1'b0;
    push(base + 6,  1, 0, "R3 high on");
    push(base + 7,  1, 0, "R6 disable latency");
    push(base + 8,  0, 0, "R6 disable overrides min on");
    push(base + 15, 0, 0, "R6 stays off");
    go(18);

    // re-enable, then lockout
    base = cyc; dis_n = 1'b1;
    push(base + 3,  0, 1, "R7 second pulse");
    push(base + 18, 1, 0, "R7 normal after pulse");
    go(25);
    base = cyc; ok = 1'b0;
    push(base + 2, 1, 0, "R9 lockout latency");
    push(base + 3, 0, 0, "R9 lockout off");
    go(8);
    base = cyc; ok = 1'b1;
    push(base + 2, 0, 0, "R9 release latency");
    push(base + 3, 1, 0, "R9 no pre-charge on release");
    go(8);

    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: %0d pending, expected 0", sb.size());
    end
    finish_run();
  end
endmodule